// File: doc/BRIEF.md
# Serial Port Data FIFO Pair with Threshold Interrupts

This block holds the transmit and receive data queues of a serial controller. Each direction owns a 256-byte store. Software picks how the store is carved into entries: 8-bit, 16-bit or 32-bit. The capacity is therefore 256, 128 or 64 entries. Software fills the transmit queue and drains the receive queue through a small register port. The serial engine pops transmit entries and pushes receive entries through dedicated strobes.

Each queue is run by a two-state controller. In IDLE, pushes and pops are ignored but the stored data is kept. In RUN, data moves. The operation register drives the transitions:

- start (write 2'b10): IDLE to RUN.
- stop (write 2'b00): RUN to IDLE.
- reset-and-stop (write 2'b01): clears the queue and enters IDLE.
- reset-and-run (write 2'b11): clears the queue and enters RUN.

Fill-level events go into a shared interrupt status register. That register is write-one-to-clear and is gated by an enable mask. The events are:

- threshold crossings;
- receive full and transmit empty;
- receive overflow and transmit underflow.

Top module: `spi_fifo_pair`

Register word addresses:

| Address | Register |
|---------|----------|
| 0 | transmit control |
| 1 | transmit operation |
| 2 | transmit status |
| 3 | transmit data (write pushes) |
| 4 | receive control |
| 5 | receive operation |
| 6 | receive status |
| 7 | receive data (read pops) |
| 8 | interrupt enable |
| 9 | interrupt status |

## Requirements
- R1: After reset both queues are in IDLE and empty. Each status word reads 0x200, with the level in bits 7:0, the full flag in bit 8 and the empty flag in bit 9. The control registers, interrupt status and interrupt enable read 0, and `irq` is 0.
- R2: In IDLE, transmit-data writes, `rx_push`, `tx_pop` and receive-data reads change neither the level nor the interrupt status.
- R3: Operation register bit 0 discards all entries and zeroes the level. Bit 1 set selects RUN and bit 1 clear selects IDLE. Stopping keeps the stored entries, and after a restart they come out in their original order.
- R4: Entries leave in the order they entered. A read of the receive data address returns the oldest entry and removes it. `tx_data` shows the oldest transmit entry, and `tx_pop` removes it.
- R5: Control bits 1:0 select the entry width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, and 3 is treated as 8-bit. Capacity is 256, 128 or 64 entries. Entries are zero-extended to 32 bits on output.
- R6: A new width in the control register takes effect only at the next write with operation bit 0 set. Until then the old width stays in force.
- R7: The full flag rises when the level equals the capacity. At 256 entries the level field reads 0 with bit 8 set. A push into a full queue is dropped. On the receive queue it sets interrupt status bit 2.
- R8: `tx_pop` on an empty running transmit queue removes nothing and sets interrupt status bit 3.
- R9: Control bits 9:2 hold an 8-bit threshold. Interrupt status bit 8 is set once each time the running receive level goes from below the threshold to at or above it.
- R10: Interrupt status bit 9 is set once each time the running transmit level goes from above the threshold to at or below it. Starting the queue counts as such a change.
- R11: Interrupt status bit 6 is set when the running receive queue becomes full. Bit 7 is set when the running transmit queue becomes empty, and starting an empty transmit queue counts as becoming empty.
- R12: Writing the interrupt status address clears exactly the bits written as one. The interrupt enable register uses the same bit positions. `irq` is the OR of the status bits that are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the receive data address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_pop | input | 1 | Serial engine takes the oldest transmit entry |
| tx_data | output | 32 | Oldest transmit entry, zero-extended |
| rx_push | input | 1 | Serial engine stores a receive entry |
| rx_data | input | 32 | Receive entry to store |
| irq | output | 1 | OR of enabled interrupt status bits |

## Verification
Stimulus is applied on the falling edge. Timing after the rising edge that takes the stimulus:

- A register write shows in the read data half a cycle later.
- A push or pop changes the level and the head entry in the same way.
- An interrupt status bit appears one edge later, because each event is detected from the registered level.
- `irq` follows the status and enable registers without further delay.

The bench therefore waits one extra falling edge before every interrupt check and samples levels straight after the strobe's edge. The edge-only threshold behaviour is checked by crossing the threshold, clearing the bit, moving further in the same direction, and confirming the bit stays clear.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [1:0] {
        EW_BYTE = 2'd0,
        EW_HALF = 2'd1,
        EW_WORD = 2'd2,
        EW_RSVD = 2'd3
    } ent_width_e;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } fifo_state_e;

    localparam int IRQ_W       = 11;
    localparam int IB_RX_OVER  = 2;
    localparam int IB_TX_UNDER = 3;
    localparam int IB_RX_FULL  = 6;
    localparam int IB_TX_EMPTY = 7;
    localparam int IB_RX_THR   = 8;
    localparam int IB_TX_THR   = 9;

    localparam logic [3:0] A_TX_CTRL = 4'd0;
    localparam logic [3:0] A_TX_OP   = 4'd1;
    localparam logic [3:0] A_TX_STAT = 4'd2;
    localparam logic [3:0] A_TX_DATA = 4'd3;
    localparam logic [3:0] A_RX_CTRL = 4'd4;
    localparam logic [3:0] A_RX_OP   = 4'd5;
    localparam logic [3:0] A_RX_STAT = 4'd6;
    localparam logic [3:0] A_RX_DATA = 4'd7;
    localparam logic [3:0] A_INT_EN  = 4'd8;
    localparam logic [3:0] A_INT_ST  = 4'd9;

    function automatic logic [1:0] width_shift(input ent_width_e w);
        case (w)
            EW_HALF: return 2'd1;
            EW_WORD: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi_fifo_lane.sv
module spi_fifo_lane
    import spi_fifo_pkg::*;
#(
    parameter int CAP_BYTES = 256,
    parameter int DATA_W    = 32,
    parameter int THR_W     = 8,
    parameter bit IS_RX     = 1'b0,
    localparam int PTR_W    = $clog2(CAP_BYTES),
    localparam int LVL_W    = PTR_W + 1,
    localparam int CTRL_W   = THR_W + 2,
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              op_wr,
    input  logic [1:0]        op_wdata,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [PTR_W-1:0]  level_lo,
    output logic              full,
    output logic              empty,
    output logic              ev_level,
    output logic              ev_edge,
    output logic              ev_error
);

    fifo_state_e       st_q, st_d;
    ent_width_e        act_w;
    logic [CTRL_W-1:0] ctrl_r;
    logic [PTR_W-1:0]  wptr, rptr, step;
    logic [LVL_W-1:0]  lvl, cap;
    logic [1:0]        shamt;
    logic [3:0]        nbytes;
    logic [THR_W-1:0]  thr;
    logic              running, clr, do_push, do_pop;
    logic              lvl_cond, edge_cond, lvl_prev, edge_prev;
    logic [7:0]        mem [CAP_BYTES];

    // Next-state logic: start, stop, reset-and-stop, reset-and-run
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE: if (op_wr && op_wdata[1])  st_d = FS_RUN;
            FS_RUN:  if (op_wr && !op_wdata[1]) st_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    // State-derived outputs
    always_comb begin
        running = 1'b0;
        unique case (st_q)
            FS_IDLE: running = 1'b0;
            FS_RUN:  running = 1'b1;
        endcase
    end

    assign clr     = op_wr && op_wdata[0];
    assign shamt   = width_shift(act_w);
    assign nbytes  = 4'd1 << shamt;
    assign step    = PTR_W'(1) << shamt;
    assign cap     = LVL_W'(CAP_BYTES) >> shamt;
    assign full    = (lvl == cap);
    assign empty   = (lvl == '0);
    assign do_push = push && running && !full;
    assign do_pop  = pop && running && !empty;
    assign thr     = ctrl_r[CTRL_W-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_r <= '0;
            act_w  <= EW_BYTE;
            wptr   <= '0;
            rptr   <= '0;
            lvl    <= '0;
        end else begin
            if (ctrl_wr) ctrl_r <= ctrl_wdata;
            if (clr) begin
                act_w <= ent_width_e'(ctrl_r[1:0]);
                wptr  <= '0;
                rptr  <= '0;
                lvl   <= '0;
            end else begin
                if (do_push) wptr <= wptr + step;
                if (do_pop)  rptr <= rptr + step;
                lvl <= lvl + LVL_W'(do_push) - LVL_W'(do_pop);
            end
        end
    end

    // Byte-lane storage: one entry spans 1, 2 or 4 consecutive bytes
    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            for (int k = 0; k < LANES; k++) begin
                if (k < int'(nbytes)) mem[wptr + PTR_W'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            head_data[8*k +: 8] = (k < int'(nbytes)) ? mem[rptr + PTR_W'(k)] : 8'h00;
        end
    end

    // Direction-specific event conditions
    generate
        if (IS_RX) begin : g_rx
            assign lvl_cond  = running && (lvl >= LVL_W'(thr));
            assign edge_cond = running && full;
            assign ev_error  = push && running && full;
        end else begin : g_tx
            assign lvl_cond  = running && (lvl <= LVL_W'(thr));
            assign edge_cond = running && empty;
            assign ev_error  = pop && running && empty;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev  <= 1'b0;
            edge_prev <= 1'b0;
        end else begin
            lvl_prev  <= lvl_cond;
            edge_prev <= edge_cond;
        end
    end

    assign ev_level = lvl_cond && !lvl_prev;
    assign ev_edge  = edge_cond && !edge_prev;
    assign ctrl_q   = ctrl_r;
    assign level_lo = lvl[PTR_W-1:0];

    p_level_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= cap);
    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !op_wr) |=> full);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !op_wr) |=> ($stable(lvl) && $stable(wptr) && $stable(rptr)));
    p_reset_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && wptr == '0 && rptr == '0));
    p_width_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(act_w));

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         en_wr,
    input  logic         st_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] st_q,
    output logic         irq
);

    logic [W-1:0] clr_mask;

    assign clr_mask = st_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_wr) en_q <= wdata;
            st_q <= (st_q & ~clr_mask) | set_i;
        end
    end

    assign irq = |(st_q & en_q);

    p_w1c_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((st_q & $past(wdata & ~set_i)) == '0));
    p_set_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int CAP_BYTES = 256,
    parameter int DATA_W    = 32,
    parameter int THR_W     = 8,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              irq
);

    localparam int PTR_W  = $clog2(CAP_BYTES);
    localparam int CTRL_W = THR_W + 2;
    localparam int ZW     = DATA_W - PTR_W - 2;

    logic [CTRL_W-1:0] tx_ctrl, rx_ctrl;
    logic [PTR_W-1:0]  tx_lvl, rx_lvl;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_evl, tx_eve, tx_err, rx_evl, rx_eve, rx_err;
    logic [DATA_W-1:0] rx_head;
    logic [IRQ_W-1:0]  irq_set, irq_en, irq_st;

    function automatic logic hit(input logic strobe, input logic [ADDR_W-1:0] a,
                                 input logic [3:0] target);
        return strobe && (a == ADDR_W'(target));
    endfunction

    spi_fifo_lane #(
        .CAP_BYTES(CAP_BYTES), .DATA_W(DATA_W), .THR_W(THR_W), .IS_RX(1'b0)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (hit(reg_wr, reg_addr, A_TX_CTRL)),
        .ctrl_wdata (reg_wdata[CTRL_W-1:0]),
        .op_wr      (hit(reg_wr, reg_addr, A_TX_OP)),
        .op_wdata   (reg_wdata[1:0]),
        .push       (hit(reg_wr, reg_addr, A_TX_DATA)),
        .push_data  (reg_wdata),
        .pop        (tx_pop),
        .head_data  (tx_data),
        .ctrl_q     (tx_ctrl),
        .level_lo   (tx_lvl),
        .full       (tx_full),
        .empty      (tx_empty),
        .ev_level   (tx_evl),
        .ev_edge    (tx_eve),
        .ev_error   (tx_err)
    );

    spi_fifo_lane #(
        .CAP_BYTES(CAP_BYTES), .DATA_W(DATA_W), .THR_W(THR_W), .IS_RX(1'b1)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (hit(reg_wr, reg_addr, A_RX_CTRL)),
        .ctrl_wdata (reg_wdata[CTRL_W-1:0]),
        .op_wr      (hit(reg_wr, reg_addr, A_RX_OP)),
        .op_wdata   (reg_wdata[1:0]),
        .push       (rx_push),
        .push_data  (rx_data),
        .pop        (hit(reg_rd, reg_addr, A_RX_DATA)),
        .head_data  (rx_head),
        .ctrl_q     (rx_ctrl),
        .level_lo   (rx_lvl),
        .full       (rx_full),
        .empty      (rx_empty),
        .ev_level   (rx_evl),
        .ev_edge    (rx_eve),
        .ev_error   (rx_err)
    );

    always_comb begin
        irq_set              = '0;
        irq_set[IB_RX_OVER]  = rx_err;
        irq_set[IB_TX_UNDER] = tx_err;
        irq_set[IB_RX_FULL]  = rx_eve;
        irq_set[IB_TX_EMPTY] = tx_eve;
        irq_set[IB_RX_THR]   = rx_evl;
        irq_set[IB_TX_THR]   = tx_evl;
    end

    spi_fifo_irq #(.W(IRQ_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .en_wr (hit(reg_wr, reg_addr, A_INT_EN)),
        .st_wr (hit(reg_wr, reg_addr, A_INT_ST)),
        .wdata (reg_wdata[IRQ_W-1:0]),
        .en_q  (irq_en),
        .st_q  (irq_st),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_TX_CTRL): reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, tx_ctrl};
            ADDR_W'(A_TX_STAT): reg_rdata = {{ZW{1'b0}}, tx_empty, tx_full, tx_lvl};
            ADDR_W'(A_RX_CTRL): reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, rx_ctrl};
            ADDR_W'(A_RX_STAT): reg_rdata = {{ZW{1'b0}}, rx_empty, rx_full, rx_lvl};
            ADDR_W'(A_RX_DATA): reg_rdata = rx_head;
            ADDR_W'(A_INT_EN):  reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, irq_en};
            ADDR_W'(A_INT_ST):  reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, irq_st};
            default:            reg_rdata = '0;
        endcase
    end

    p_irq_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_st & irq_en) == '0) |-> !irq);

endmodule

// File: tb/spi_fifo_pair_test.sv
`timescale 1ns/1ps
module spi_fifo_pair_test;

    localparam logic [3:0] TXC = 4'd0, TXO = 4'd1, TXS = 4'd2, TXD = 4'd3;
    localparam logic [3:0] RXC = 4'd4, RXO = 4'd5, RXS = 4'd6, RXD = 4'd7;
    localparam logic [3:0] IEN = 4'd8, IST = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tx_pop = 1'b0, rx_push = 1'b0, irq;
    logic [31:0] tx_data, rx_data = '0;
    int          nchk = 0, nfail = 0;
    bit          done = 1'b0;

    spi_fifo_pair uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push),
        .rx_data(rx_data), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rxp(input logic [31:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic txp(output logic [31:0] d);
        @(negedge clk);
        tx_pop = 1'b1;
        #1 d = tx_data;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(TXS, v); chk("R1 tx status", v, 32'h200);
        peek(RXS, v); chk("R1 rx status", v, 32'h200);
        peek(TXC, v); chk("R1 tx ctrl", v, 32'h0);
        peek(IST, v); chk("R1 int status", v, 32'h0);
        peek(IEN, v); chk("R1 int enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        rxp(32'h11); rxp(32'h22);
        wr(TXD, 32'h33);
        txp(v);
        rd(RXD, v);
        tick();
        peek(RXS, v); chk("R2 rx level idle", v, 32'h200);
        peek(TXS, v); chk("R2 tx level idle", v, 32'h200);
        peek(IST, v); chk("R2 no events idle", v, 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        wr(RXC, 32'd200 << 2);
        wr(RXO, 32'h3);
        rxp(32'hA5); rxp(32'h3C); rxp(32'h7E);
        peek(RXS, v); chk("R4 rx level 3", v, 32'h003);
        rd(RXD, v); chk("R4 first out", v, 32'hA5);
        rd(RXD, v); chk("R4 second out", v, 32'h3C);
        rd(RXD, v); chk("R4 third out", v, 32'h7E);
        peek(RXS, v); chk("R4 drained", v, 32'h200);
    endtask

    task automatic t_ops();
        logic [31:0] v;
        rxp(32'h0A); rxp(32'h0B);
        wr(RXO, 32'h0);
        rxp(32'h0C);
        rd(RXD, v);
        peek(RXS, v); chk("R3 stop keeps data", v, 32'h002);
        wr(RXO, 32'h2);
        rd(RXD, v); chk("R3 restart order", v, 32'h0A);
        wr(RXO, 32'h1);
        peek(RXS, v); chk("R3 reset clears", v, 32'h200);
        rxp(32'h0D);
        peek(RXS, v); chk("R3 reset stops", v, 32'h200);
        wr(RXO, 32'h2);
    endtask

    task automatic t_width();
        logic [31:0] v;
        wr(RXC, 32'h2);
        rxp(32'h11223344);
        rd(RXD, v); chk("R6 old width kept", v, 32'h44);
        wr(RXO, 32'h3);
        rxp(32'hDEADBEEF); rxp(32'h01020304);
        peek(RXS, v); chk("R5 dword level", v, 32'h002);
        rd(RXD, v); chk("R5 dword first", v, 32'hDEADBEEF);
        rd(RXD, v); chk("R5 dword second", v, 32'h01020304);
        wr(RXC, 32'h1); wr(RXO, 32'h3);
        rxp(32'hABCD1234);
        rd(RXD, v); chk("R5 half zero-extend", v, 32'h1234);
        wr(RXC, 32'h3); wr(RXO, 32'h3);
        rxp(32'h000055AA);
        rd(RXD, v); chk("R5 code 3 is byte", v, 32'hAA);
        wr(RXC, 32'h2); wr(RXO, 32'h3);
        tick(); wr(IST, 32'h7FF);
        for (int k = 0; k < 64; k++) rxp(32'h100 + k);
        tick();
        peek(RXS, v); chk("R7 dword full at 64", v, 32'h140);
        rxp(32'hFFFF);
        tick();
        peek(IST, v); chk("R7 R11 overflow and full bits", v & 32'h44, 32'h44);
        rd(RXD, v); chk("R7 oldest kept", v, 32'h100);
        wr(RXC, 32'h0); wr(RXO, 32'h3);
        for (int k = 0; k < 256; k++) rxp(k);
        peek(RXS, v); chk("R7 byte full at 256", v, 32'h100);
        rxp(32'h77);
        rd(RXD, v); chk("R7 drop when full", v, 32'h00);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        wr(TXC, 32'd2 << 2);
        wr(TXO, 32'h3);
        tick();
        peek(IST, v); chk("R10 R11 start events", v & 32'h280, 32'h280);
        wr(IST, 32'h7FF);
        for (int k = 0; k < 5; k++) wr(TXD, 32'h10 + k);
        peek(TXS, v); chk("R4 tx level 5", v, 32'h005);
        for (int k = 0; k < 3; k++) begin
            txp(v); chk("R4 tx order", v, 32'h10 + k);
        end
        tick();
        peek(IST, v); chk("R10 tx threshold crossed", v, 32'h200);
        txp(v); txp(v); chk("R4 tx last", v, 32'h14);
        tick();
        peek(IST, v); chk("R11 tx became empty", v, 32'h280);
        txp(v);
        tick();
        peek(IST, v); chk("R8 underflow", v, 32'h288);
        peek(TXS, v); chk("R8 level stays 0", v, 32'h200);
    endtask

    task automatic t_rxthr();
        logic [31:0] v;
        wr(RXC, 32'd3 << 2);
        wr(RXO, 32'h3);
        tick(); wr(IST, 32'h7FF);
        rxp(32'h1); rxp(32'h2);
        tick();
        peek(IST, v); chk("R9 below threshold", v, 32'h0);
        rxp(32'h3);
        tick();
        peek(IST, v); chk("R9 threshold reached", v, 32'h100);
        wr(IST, 32'h100);
        rxp(32'h4);
        tick();
        peek(IST, v); chk("R9 no refire above", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(IEN, 32'h100);
        chk("R12 irq low no status", {31'b0, irq}, 32'h0);
        rd(RXD, v); rd(RXD, v);
        rxp(32'h5);
        tick();
        chk("R12 irq on enabled bit", {31'b0, irq}, 32'h1);
        wr(IEN, 32'h0);
        chk("R12 irq masked", {31'b0, irq}, 32'h0);
        wr(IEN, 32'h100);
        wr(IST, 32'h004);
        peek(IST, v); chk("R12 other bit write keeps", v, 32'h100);
        wr(IST, 32'h100);
        peek(IST, v); chk("R12 w1c clears", v, 32'h0);
        chk("R12 irq drops", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_idle();
        t_order();
        t_ops();
        t_width();
        t_tx();
        t_rxthr();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule